// File: doc/BRIEF.md
# DMA Descriptor Register Bank

This block is the software-facing register file of a single-channel two-dimensional DMA engine. A host programs the transfer through 32-bit registers: the flags, the source and destination addresses, the X and Y lengths and the two strides. A write to the start register copies the whole set into a small descriptor queue and tags it with a transfer ID. The data mover on the far side pulls descriptors from the queue. It reports each completed ID back, and the bank records it in a bitmap of finished transfers and raises an end-of-transfer interrupt.

Several registers have bits that are fixed in hardware, and software finds the engine's abilities by writing a value and reading it back. The low bits of the X length are tied to one, so a written zero reads back as the length alignment mask. The upper X length bits are tied to zero, so a written all-ones value reads back as the largest length minus one. An address register on a side that is not memory-mapped always reads zero. The cyclic flag reads back zero when cyclic transfers are not built in.

The bus is a simple strobe interface. Writes take effect at the clock edge. Read data is registered and appears one cycle after the read strobe, together with a valid pulse.

Top module: `dma_desc_regbank`

## Requirements
- R1: After reset, control (0x400) reads 0, interrupt mask (0x080) reads 3, next ID (0x404) reads 0, interrupt source (0x084) reads 0, and `irq` and `desc_valid` are low.
- R2: X length (0x418) reads back with bits [1:0] forced to one and bits [31:24] forced to zero. Y length (0x41C) keeps bits [15:0] and reads zero above them.
- R3: Destination address (0x410, memory-mapped side) reads back with bits [1:0] zero. Source address (0x414, not memory-mapped) always reads 0. Both strides (0x420, 0x424) keep all 32 bits.
- R4: Flags (0x40C) keep bit 0 (cyclic) and bit 1 (last segment), and every other bit reads 0.
- R5: Writing bit 0 = 1 to start (0x408) while control bit 0 (enable) is 1 and the queue is not full captures the current register readbacks into the queue with ID = next ID. The next ID then increments modulo 32.
- R6: A start write while disabled, or while the queue already holds 4 entries, is ignored and the next ID is unchanged. Start bit 0 reads 1 while the queue is full.
- R7: `desc_valid` is high only when the queue is non-empty, enable is 1 and control bit 1 (pause) is 0. Descriptors leave the queue in submission order, one per cycle in which `desc_pop` is high with `desc_valid`.
- R8: Clearing enable empties the queue, so re-enabling does not bring back descriptors submitted earlier.
- R9: Source bit 0 is set when a descriptor is popped (start of transfer), and source bit 1 is set on `done_valid` (end of transfer). Pending (0x088) reads source AND NOT mask. Writing ones to pending clears those source bits, and a new event in the same cycle wins.
- R10: `irq` is high exactly when some pending bit is set, and it changes at the same edge as the source or mask.
- R11: A `done_valid` cycle sets bit `done_id` of the transfer-done register (0x428). Writing ones there clears those bits.
- R12: Status (0x430) bit 0 reflects `eng_busy`. Registers 0x434 and 0x438 read `cur_src` and `cur_dst`, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd` |
| reg_rvalid | output | 1 | Read data valid |
| desc_valid | output | 1 | Queue head available to the mover |
| desc_pop | input | 1 | Mover takes the queue head |
| desc_id | output | 5 | Transfer ID of the head |
| desc_flags | output | 2 | Flags of the head |
| desc_dst | output | 32 | Destination address of the head |
| desc_src | output | 32 | Source address of the head |
| desc_xlen | output | 32 | X length minus one of the head |
| desc_ylen | output | 32 | Y length minus one of the head |
| desc_dstride | output | 32 | Destination stride of the head |
| desc_sstride | output | 32 | Source stride of the head |
| done_valid | input | 1 | Mover reports a completed transfer |
| done_id | input | 5 | ID of the completed transfer |
| eng_busy | input | 1 | Mover busy indication |
| cur_src | input | 32 | Mover's current source address |
| cur_dst | input | 32 | Mover's current destination address |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach from the ports are the ID wrap from 31 back to 0 and a start write that arrives while the queue is full. To reach the wrap, a randomized loop of more than 32 program-start-pop rounds runs, each round with fresh register values. To reach the full queue, a directed sequence submits five descriptors with no pops and then checks that the fifth changed neither the ID nor the contents of the queue. The flush on disable is driven directly: two descriptors are queued, enable is cleared, and `desc_valid` is checked after re-enabling.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;
  localparam int REG_AW = 12;
  localparam int ID_W   = 5;
  localparam int IRQ_W  = 2;

  localparam logic [REG_AW-1:0] OFF_IRQ_MASK = 12'h080;
  localparam logic [REG_AW-1:0] OFF_IRQ_SRC  = 12'h084;
  localparam logic [REG_AW-1:0] OFF_IRQ_PEND = 12'h088;
  localparam logic [REG_AW-1:0] OFF_CTRL     = 12'h400;
  localparam logic [REG_AW-1:0] OFF_NEXT_ID  = 12'h404;
  localparam logic [REG_AW-1:0] OFF_START    = 12'h408;
  localparam logic [REG_AW-1:0] OFF_FLAGS    = 12'h40C;
  localparam logic [REG_AW-1:0] OFF_DST      = 12'h410;
  localparam logic [REG_AW-1:0] OFF_SRC      = 12'h414;
  localparam logic [REG_AW-1:0] OFF_XLEN     = 12'h418;
  localparam logic [REG_AW-1:0] OFF_YLEN     = 12'h41C;
  localparam logic [REG_AW-1:0] OFF_DSTRIDE  = 12'h420;
  localparam logic [REG_AW-1:0] OFF_SSTRIDE  = 12'h424;
  localparam logic [REG_AW-1:0] OFF_DONE     = 12'h428;
  localparam logic [REG_AW-1:0] OFF_STATUS   = 12'h430;
  localparam logic [REG_AW-1:0] OFF_CUR_SRC  = 12'h434;
  localparam logic [REG_AW-1:0] OFF_CUR_DST  = 12'h438;

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic [1:0]      flags;
    logic [31:0]     dst;
    logic [31:0]     src;
    logic [31:0]     xlen;
    logic [31:0]     ylen;
    logic [31:0]     dstride;
    logic [31:0]     sstride;
  } dma_desc_t;
endpackage

// File: rtl/dma_rb_cfg.sv
module dma_rb_cfg #(
  parameter int LEN_W           = 24,
  parameter int LEN_ALIGN_BITS  = 2,
  parameter int YLEN_W          = 16,
  parameter int ADDR_ALIGN_BITS = 2,
  parameter bit DST_MM          = 1'b1,
  parameter bit SRC_MM          = 1'b0,
  parameter bit CYCLIC_EN       = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] wdata,
  input  logic        wr_ctrl,
  input  logic        wr_flags,
  input  logic        wr_dst,
  input  logic        wr_src,
  input  logic        wr_xlen,
  input  logic        wr_ylen,
  input  logic        wr_dstride,
  input  logic        wr_sstride,
  output logic        ctrl_en,
  output logic        ctrl_pause,
  output logic [1:0]  flags_rd,
  output logic [31:0] dst_rd,
  output logic [31:0] src_rd,
  output logic [31:0] xlen_rd,
  output logic [31:0] ylen_rd,
  output logic [31:0] dstride_rd,
  output logic [31:0] sstride_rd
);
  logic [LEN_W-1:LEN_ALIGN_BITS] xlen_q;
  logic [YLEN_W-1:0]             ylen_q;
  logic                          last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en    <= 1'b0;
      ctrl_pause <= 1'b0;
      xlen_q     <= '0;
      ylen_q     <= '0;
      last_q     <= 1'b0;
      dstride_rd <= '0;
      sstride_rd <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en    <= wdata[0];
        ctrl_pause <= wdata[1];
      end
      if (wr_xlen)    xlen_q     <= wdata[LEN_W-1:LEN_ALIGN_BITS];
      if (wr_ylen)    ylen_q     <= wdata[YLEN_W-1:0];
      if (wr_flags)   last_q     <= wdata[1];
      if (wr_dstride) dstride_rd <= wdata;
      if (wr_sstride) sstride_rd <= wdata;
    end
  end

  // Hardwired ones below the alignment, zeros above the supported length
  assign xlen_rd = 32'({xlen_q, {LEN_ALIGN_BITS{1'b1}}});
  assign ylen_rd = 32'(ylen_q);

  generate
    if (CYCLIC_EN) begin : g_cyclic
      logic cyc_q;
      always_ff @(posedge clk) begin
        if (rst)           cyc_q <= 1'b0;
        else if (wr_flags) cyc_q <= wdata[0];
      end
      assign flags_rd = {last_q, cyc_q};
    end else begin : g_no_cyclic
      assign flags_rd = {last_q, 1'b0};
    end

    if (DST_MM) begin : g_dst_mm
      logic [31:ADDR_ALIGN_BITS] dst_q;
      always_ff @(posedge clk) begin
        if (rst)         dst_q <= '0;
        else if (wr_dst) dst_q <= wdata[31:ADDR_ALIGN_BITS];
      end
      assign dst_rd = {dst_q, {ADDR_ALIGN_BITS{1'b0}}};
    end else begin : g_dst_stream
      logic unused_dst_wr;
      assign unused_dst_wr = wr_dst;
      assign dst_rd = '0;
    end

    if (SRC_MM) begin : g_src_mm
      logic [31:ADDR_ALIGN_BITS] src_q;
      always_ff @(posedge clk) begin
        if (rst)         src_q <= '0;
        else if (wr_src) src_q <= wdata[31:ADDR_ALIGN_BITS];
      end
      assign src_rd = {src_q, {ADDR_ALIGN_BITS{1'b0}}};
    end else begin : g_src_stream
      logic unused_src_wr;
      assign unused_src_wr = wr_src;
      assign src_rd = '0;
    end
  endgenerate
endmodule

// File: rtl/dma_rb_queue.sv
module dma_rb_queue
  import dma_rb_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      flush,
  input  logic      push,
  input  dma_desc_t din,
  input  logic      pop,
  output dma_desc_t dout,
  output logic      empty,
  output logic      full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  dma_desc_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign dout  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/dma_rb_irq.sv
module dma_rb_irq
  import dma_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sot_evt,
  input  logic              eot_evt,
  input  logic [ID_W-1:0]   eot_id,
  input  logic              mask_wr,
  input  logic              pend_wr,
  input  logic              done_wr,
  input  logic [31:0]       wdata,
  output logic [IRQ_W-1:0]  mask_q,
  output logic [IRQ_W-1:0]  src_q,
  output logic [31:0]       done_q,
  output logic              irq_o
);
  logic [IRQ_W-1:0] src_n, mask_n;
  logic [31:0]      done_n;

  always_comb begin
    mask_n = mask_wr ? wdata[IRQ_W-1:0] : mask_q;
    src_n  = src_q & ~(pend_wr ? wdata[IRQ_W-1:0] : '0);
    src_n  = src_n | {eot_evt, sot_evt};
    done_n = done_q & ~(done_wr ? wdata : 32'd0);
    if (eot_evt) done_n[eot_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      src_q  <= '0;
      done_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      mask_q <= mask_n;
      src_q  <= src_n;
      done_q <= done_n;
      irq_o  <= |(src_n & ~mask_n);
    end
  end

  p_sot_sets_r9: assert property (@(posedge clk) disable iff (rst)
    sot_evt |=> src_q[0]);
  p_eot_sets_r9: assert property (@(posedge clk) disable iff (rst)
    eot_evt |=> src_q[1]);
  p_irq_pending_r10: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(src_q & ~mask_q));
  p_done_bit_r11: assert property (@(posedge clk) disable iff (rst)
    eot_evt |=> done_q[$past(eot_id)]);
endmodule

// File: rtl/dma_desc_regbank.sv
module dma_desc_regbank
  import dma_rb_pkg::*;
#(
  parameter int QUEUE_DEPTH     = 4,
  parameter int LEN_W           = 24,
  parameter int LEN_ALIGN_BITS  = 2,
  parameter int YLEN_W          = 16,
  parameter int ADDR_ALIGN_BITS = 2,
  parameter bit DST_MM          = 1'b1,
  parameter bit SRC_MM          = 1'b0,
  parameter bit CYCLIC_EN       = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        reg_rvalid,
  output logic        desc_valid,
  input  logic        desc_pop,
  output logic [4:0]  desc_id,
  output logic [1:0]  desc_flags,
  output logic [31:0] desc_dst,
  output logic [31:0] desc_src,
  output logic [31:0] desc_xlen,
  output logic [31:0] desc_ylen,
  output logic [31:0] desc_dstride,
  output logic [31:0] desc_sstride,
  input  logic        done_valid,
  input  logic [4:0]  done_id,
  input  logic        eng_busy,
  input  logic [31:0] cur_src,
  input  logic [31:0] cur_dst,
  output logic        irq
);
  logic              ctrl_en, ctrl_pause;
  logic [1:0]        flags_rd;
  logic [31:0]       dst_rd, src_rd, xlen_rd, ylen_rd, dstride_rd, sstride_rd;
  logic [IRQ_W-1:0]  mask_q, src_q;
  logic [31:0]       done_q;
  logic [ID_W-1:0]   next_id;
  logic              q_empty, q_full, push_ok, pop_ok;
  dma_desc_t         q_din, q_dout;

  function automatic logic hit(input logic [REG_AW-1:0] off);
    return reg_wr && (reg_addr == off);
  endfunction

  dma_rb_cfg #(
    .LEN_W(LEN_W), .LEN_ALIGN_BITS(LEN_ALIGN_BITS), .YLEN_W(YLEN_W),
    .ADDR_ALIGN_BITS(ADDR_ALIGN_BITS), .DST_MM(DST_MM), .SRC_MM(SRC_MM),
    .CYCLIC_EN(CYCLIC_EN)
  ) cfg_i (
    .clk(clk), .rst(rst), .wdata(reg_wdata),
    .wr_ctrl(hit(OFF_CTRL)), .wr_flags(hit(OFF_FLAGS)),
    .wr_dst(hit(OFF_DST)), .wr_src(hit(OFF_SRC)),
    .wr_xlen(hit(OFF_XLEN)), .wr_ylen(hit(OFF_YLEN)),
    .wr_dstride(hit(OFF_DSTRIDE)), .wr_sstride(hit(OFF_SSTRIDE)),
    .ctrl_en(ctrl_en), .ctrl_pause(ctrl_pause), .flags_rd(flags_rd),
    .dst_rd(dst_rd), .src_rd(src_rd), .xlen_rd(xlen_rd), .ylen_rd(ylen_rd),
    .dstride_rd(dstride_rd), .sstride_rd(sstride_rd)
  );

  assign push_ok    = hit(OFF_START) && reg_wdata[0] && ctrl_en && !q_full;
  assign desc_valid = !q_empty && ctrl_en && !ctrl_pause;
  assign pop_ok     = desc_pop && desc_valid;

  always_comb begin
    q_din.id      = next_id;
    q_din.flags   = flags_rd;
    q_din.dst     = dst_rd;
    q_din.src     = src_rd;
    q_din.xlen    = xlen_rd;
    q_din.ylen    = ylen_rd;
    q_din.dstride = dstride_rd;
    q_din.sstride = sstride_rd;
  end

  dma_rb_queue #(.DEPTH(QUEUE_DEPTH)) queue_i (
    .clk(clk), .rst(rst), .flush(!ctrl_en), .push(push_ok), .din(q_din),
    .pop(pop_ok), .dout(q_dout), .empty(q_empty), .full(q_full)
  );

  assign desc_id      = q_dout.id;
  assign desc_flags   = q_dout.flags;
  assign desc_dst     = q_dout.dst;
  assign desc_src     = q_dout.src;
  assign desc_xlen    = q_dout.xlen;
  assign desc_ylen    = q_dout.ylen;
  assign desc_dstride = q_dout.dstride;
  assign desc_sstride = q_dout.sstride;

  dma_rb_irq irq_i (
    .clk(clk), .rst(rst), .sot_evt(pop_ok), .eot_evt(done_valid),
    .eot_id(done_id), .mask_wr(hit(OFF_IRQ_MASK)), .pend_wr(hit(OFF_IRQ_PEND)),
    .done_wr(hit(OFF_DONE)), .wdata(reg_wdata), .mask_q(mask_q), .src_q(src_q),
    .done_q(done_q), .irq_o(irq)
  );

  always_ff @(posedge clk) begin
    if (rst)          next_id <= '0;
    else if (push_ok) next_id <= next_id + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) begin
        case (reg_addr)
          OFF_IRQ_MASK: reg_rdata <= 32'(mask_q);
          OFF_IRQ_SRC:  reg_rdata <= 32'(src_q);
          OFF_IRQ_PEND: reg_rdata <= 32'(src_q & ~mask_q);
          OFF_CTRL:     reg_rdata <= {30'd0, ctrl_pause, ctrl_en};
          OFF_NEXT_ID:  reg_rdata <= 32'(next_id);
          OFF_START:    reg_rdata <= {31'd0, q_full};
          OFF_FLAGS:    reg_rdata <= {30'd0, flags_rd};
          OFF_DST:      reg_rdata <= dst_rd;
          OFF_SRC:      reg_rdata <= src_rd;
          OFF_XLEN:     reg_rdata <= xlen_rd;
          OFF_YLEN:     reg_rdata <= ylen_rd;
          OFF_DSTRIDE:  reg_rdata <= dstride_rd;
          OFF_SSTRIDE:  reg_rdata <= sstride_rd;
          OFF_DONE:     reg_rdata <= done_q;
          OFF_STATUS:   reg_rdata <= {31'd0, eng_busy};
          OFF_CUR_SRC:  reg_rdata <= cur_src;
          OFF_CUR_DST:  reg_rdata <= cur_dst;
          default:      reg_rdata <= '0;
        endcase
      end
    end
  end

  p_id_step_r5: assert property (@(posedge clk) disable iff (rst)
    push_ok |=> next_id == ID_W'($past(next_id) + 1'b1));
  p_full_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (hit(OFF_START) && q_full && !pop_ok) |=> $stable(next_id));
  p_valid_ctrl_r7: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && !ctrl_en) == 1'b0);
endmodule

// File: tb/dma_desc_regbank_tb_top.sv
module dma_desc_regbank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr = 0, reg_rd = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        reg_rvalid, desc_valid, desc_pop = 0;
  logic [4:0]  desc_id, done_id = '0;
  logic [1:0]  desc_flags;
  logic [31:0] desc_dst, desc_src, desc_xlen, desc_ylen, desc_dstride, desc_sstride;
  logic        done_valid = 0, eng_busy = 0, irq;
  logic [31:0] cur_src = '0, cur_dst = '0;

  int errors = 0, checks = 0;
  logic [31:0] rv;
  logic [4:0]  exp_id;
  logic [31:0] exp_x [8];
  logic [31:0] exp_d [8];
  logic [4:0]  exp_i [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_desc_regbank dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .desc_valid(desc_valid), .desc_pop(desc_pop), .desc_id(desc_id),
    .desc_flags(desc_flags), .desc_dst(desc_dst), .desc_src(desc_src),
    .desc_xlen(desc_xlen), .desc_ylen(desc_ylen), .desc_dstride(desc_dstride),
    .desc_sstride(desc_sstride), .done_valid(done_valid), .done_id(done_id),
    .eng_busy(eng_busy), .cur_src(cur_src), .cur_dst(cur_dst), .irq(irq)
  );

  function automatic logic [31:0] f_xlen(input logic [31:0] v);
    return (v & 32'h00FF_FFFF) | 32'h3;
  endfunction
  function automatic logic [31:0] f_dst(input logic [31:0] v);
    return v & 32'hFFFF_FFFC;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic pop_check(input string req, input logic [4:0] id,
                           input logic [31:0] x, input logic [31:0] d);
    check({req, " valid"}, 32'(desc_valid), 32'd1);
    check({req, " id"}, 32'(desc_id), 32'(id));
    check({req, " xlen"}, desc_xlen, x);
    check({req, " dst"}, desc_dst, d);
    desc_pop = 1;
    @(negedge clk);
    desc_pop = 0;
  endtask

  task automatic push(input logic [31:0] x, input logic [31:0] d);
    wr(12'h418, x);
    wr(12'h410, d);
    wr(12'h408, 32'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    rd(12'h400, rv); check("R1 ctrl", rv, 0);
    rd(12'h080, rv); check("R1 mask", rv, 3);
    rd(12'h404, rv); check("R1 next id", rv, 0);
    rd(12'h084, rv); check("R1 source", rv, 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 desc_valid", 32'(desc_valid), 0);

    // R2 length capability readback
    wr(12'h418, 0);             rd(12'h418, rv); check("R2 align mask", rv, 32'h3);
    wr(12'h418, 32'hFFFF_FFFF); rd(12'h418, rv); check("R2 max len", rv, 32'h00FF_FFFF);
    wr(12'h41C, 32'hFFFF_FFFF); rd(12'h41C, rv); check("R2 ylen", rv, 32'h0000_FFFF);
    // R3 address sides
    wr(12'h410, 32'hFFFF_FFFF); rd(12'h410, rv); check("R3 dst mm", rv, 32'hFFFF_FFFC);
    wr(12'h414, 32'hFFFF_FFFF); rd(12'h414, rv); check("R3 src stream", rv, 0);
    wr(12'h420, 32'hDEAD_BEEF); rd(12'h420, rv); check("R3 dstride", rv, 32'hDEAD_BEEF);
    // R4 flags
    wr(12'h40C, 32'hFFFF_FFFF); rd(12'h40C, rv); check("R4 flags all", rv, 3);
    wr(12'h40C, 32'h1);         rd(12'h40C, rv); check("R4 cyclic only", rv, 1);

    // R6 start while disabled is ignored
    wr(12'h408, 1);
    rd(12'h404, rv); check("R6 disabled id", rv, 0);
    check("R6 disabled valid", 32'(desc_valid), 0);

    // R5 capture and R6 full queue
    wr(12'h400, 1);
    exp_id = 0;
    for (int i = 0; i < 4; i++) begin
      exp_x[i] = f_xlen(32'h100 * (i + 1) + 32'h5);
      exp_d[i] = f_dst(32'h8000_0000 + 32'h11 * i);
      exp_i[i] = exp_id;
      push(32'h100 * (i + 1) + 32'h5, 32'h8000_0000 + 32'h11 * i);
      exp_id++;
    end
    rd(12'h404, rv); check("R5 next id after 4", rv, 4);
    rd(12'h408, rv); check("R6 full flag", rv, 1);
    push(32'h777, 32'h4444);
    rd(12'h404, rv); check("R6 full id unchanged", rv, 4);

    // R7 pause gating
    wr(12'h400, 3);
    check("R7 paused", 32'(desc_valid), 0);
    wr(12'h400, 1);
    for (int i = 0; i < 4; i++) pop_check("R7 R5 order", exp_i[i], exp_x[i], exp_d[i]);
    check("R7 drained", 32'(desc_valid), 0);

    // R9 / R10 interrupt handling
    rd(12'h084, rv); check("R9 sot source", rv, 1);
    rd(12'h088, rv); check("R9 masked pending", rv, 0);
    check("R10 masked irq", 32'(irq), 0);
    wr(12'h080, 0);
    check("R10 irq on unmask", 32'(irq), 1);
    wr(12'h088, 1);
    rd(12'h084, rv); check("R9 w1c source", rv, 0);
    check("R10 irq cleared", 32'(irq), 0);

    // R11 done bitmap and EOT
    done_id = 5'd7; done_valid = 1;
    @(negedge clk);
    done_valid = 0;
    check("R10 irq on eot", 32'(irq), 1);
    rd(12'h428, rv); check("R11 done bit", rv, 32'h80);
    rd(12'h084, rv); check("R9 eot source", rv, 2);
    wr(12'h428, 32'h80); rd(12'h428, rv); check("R11 w1c done", rv, 0);
    wr(12'h088, 2);
    check("R10 irq after eot clear", 32'(irq), 0);

    // R8 flush on disable
    push(32'h10, 32'h20);
    push(32'h30, 32'h40);
    exp_id = exp_id + 2;
    check("R8 queued", 32'(desc_valid), 1);
    wr(12'h400, 0);
    wr(12'h400, 1);
    check("R8 flushed", 32'(desc_valid), 0);

    // R12 status and current addresses
    eng_busy = 1; cur_src = 32'h1234_5678; cur_dst = 32'h9ABC_DEF0;
    rd(12'h430, rv); check("R12 status", rv, 1);
    rd(12'h434, rv); check("R12 cur src", rv, 32'h1234_5678);
    rd(12'h438, rv); check("R12 cur dst", rv, 32'h9ABC_DEF0);
    rd(12'h3FC, rv); check("R12 unmapped", rv, 0);

    // Random rounds: wraps the ID past 31 (R5) and rechecks readbacks (R2 R3 R4)
    wr(12'h080, 3);
    for (int n = 0; n < 40; n++) begin
      logic [31:0] x, d, s, f, y;
      x = $urandom; d = $urandom; s = $urandom; f = $urandom; y = $urandom;
      wr(12'h40C, f);
      wr(12'h414, s);
      wr(12'h41C, y);
      push(x, d);
      check("R4 rand flags", 32'(desc_flags), f & 3);
      check("R3 rand src", desc_src, 0);
      check("R2 rand ylen", desc_ylen, y & 32'hFFFF);
      pop_check("R5 rand", exp_id, f_xlen(x), f_dst(d));
      exp_id++;
    end
    rd(12'h404, rv); check("R5 id wrap", rv, 32'(exp_id));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule